// File: doc/BRIEF.md
# Keyboard and Display Register Slave

This block sits on a processor's memory bus and gives software access to one character input device and one character output device. Four 32-bit words at the base of a high address window hold these registers: a status/control word and a data word for each device. Software polls bit 0 of a control word, or enables that device's interrupt and waits for the request line. It then reads or writes the matching data word.

On the input side, a one-cycle strobe delivers a byte. The block holds the byte and marks the keyboard as ready until software reads it. On the output side, a software write hands a byte to the display through a one-cycle valid pulse. The display is marked busy until the display acknowledges the byte. A registered interrupt request combines each ready flag with its enable bit.

Top module: `kbd_disp_regs`

## Requirements
- R1: After reset the keyboard control word reads 0 and the display control word reads 1 (ready, interrupt disabled). `irq` and `disp_valid` are 0.
- R2: The block responds only when `bus_sel` is 1 and `bus_addr[31:8]` equals 0xFFFF00. For any other address a read returns 0, and reads or writes change no state.
- R3: A `key_valid` strobe stores `key_byte` and sets keyboard ready (control offset 0x0, bit 0). A read of keyboard data (offset 0x4, byte in bits 7:0) returns that byte and clears keyboard ready. If a strobe and a data read fall in the same cycle, the strobe wins: ready stays 1 and the new byte is held.
- R4: A write to display data (offset 0xC) while display ready (offset 0x8, bit 0) is 1 has three results in the next cycle: `disp_valid` pulses for exactly one cycle, `disp_byte` equals `bus_wdata[7:0]`, and display ready reads 0. Display ready returns to 1 in the cycle after `disp_ack`. A read of offset 0xC returns the last byte forwarded.
- R5: A write to display data while display ready is 0 is ignored: no `disp_valid` pulse, and `disp_byte` is unchanged.
- R6: Bit 1 of each control word is the interrupt enable; writes set it and reads return it. Bit 0 is read-only, and writes to it are ignored. Bits 31:2 of the control words and bits 31:8 of the data words read 0.
- R7: `irq` is registered. It equals (keyboard ready AND keyboard enable) OR (display ready AND display enable), evaluated one clock earlier.
- R8: Reads of offsets 0x10 to 0xFC inside the window return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| key_valid | input | 1 | One-cycle strobe of a new key byte |
| key_byte | input | 8 | Key byte |
| disp_valid | output | 1 | One-cycle pulse: byte handed to display |
| disp_byte | output | 8 | Byte for the display |
| disp_ack | input | 1 | Display has taken the byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are those where two events meet in one cycle. A key strobe can land in the same cycle as the data read that would clear the flag. A display write can arrive while the previous byte is still unacknowledged. The bench forces both by driving the strobe and the bus read on the same falling edge, and by issuing a second display write before any acknowledge. It then sweeps all sixteen combinations of the two ready flags and two enables, bringing each flag to its state through the normal device handshakes before it checks the interrupt line.

// File: rtl/kbd_disp_regs.sv
module kbd_disp_regs #(
  parameter logic [31:0] BASE     = 32'hFFFF_0000,
  parameter int          WIN_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        key_valid,
  input  logic [7:0]  key_byte,
  output logic        disp_valid,
  output logic [7:0]  disp_byte,
  input  logic        disp_ack,
  output logic        irq
);
  localparam int OFF_W = WIN_BITS - 2;

  logic             hit;
  logic [OFF_W-1:0] off;
  logic             rd_kd, wr_kc, wr_dc, wr_dd;
  logic             kbd_r, kbd_ie, dsp_r, dsp_ie, dsp_vld, irq_q;
  logic [7:0]       kbd_data, dsp_data;

  assign hit   = bus_sel && (bus_addr[31:WIN_BITS] == BASE[31:WIN_BITS]);
  assign off   = bus_addr[WIN_BITS-1:2];
  assign rd_kd = hit && !bus_we && off == OFF_W'(1);
  assign wr_kc = hit &&  bus_we && off == OFF_W'(0);
  assign wr_dc = hit &&  bus_we && off == OFF_W'(2);
  assign wr_dd = hit &&  bus_we && off == OFF_W'(3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbd_r    <= 1'b0;
      kbd_ie   <= 1'b0;
      kbd_data <= '0;
    end else begin
      if (key_valid) begin
        kbd_r    <= 1'b1;
        kbd_data <= key_byte;
      end else if (rd_kd) begin
        kbd_r    <= 1'b0;
      end
      if (wr_kc) kbd_ie <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_r    <= 1'b1;
      dsp_ie   <= 1'b0;
      dsp_data <= '0;
      dsp_vld  <= 1'b0;
    end else begin
      dsp_vld <= 1'b0;
      if (wr_dd && dsp_r) begin
        dsp_r    <= 1'b0;
        dsp_data <= bus_wdata[7:0];
        dsp_vld  <= 1'b1;
      end else if (disp_ack && !dsp_r) begin
        dsp_r    <= 1'b1;
      end
      if (wr_dc) dsp_ie <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (kbd_r & kbd_ie) | (dsp_r & dsp_ie);
  end

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_we) begin
      case (off)
        OFF_W'(0): bus_rdata = {30'd0, kbd_ie, kbd_r};
        OFF_W'(1): bus_rdata = {24'd0, kbd_data};
        OFF_W'(2): bus_rdata = {30'd0, dsp_ie, dsp_r};
        OFF_W'(3): bus_rdata = {24'd0, dsp_data};
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign disp_valid = dsp_vld;
  assign disp_byte  = dsp_data;
  assign irq        = irq_q;
endmodule

// File: rtl/kbd_disp_regs_chk.sv
module kbd_disp_regs_chk #(
  parameter logic [31:0] BASE     = 32'hFFFF_0000,
  parameter int          WIN_BITS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic        key_valid,
  input logic        disp_valid,
  input logic        irq,
  input logic        kbd_r,
  input logic        kbd_ie,
  input logic        dsp_r,
  input logic        dsp_ie
);
  logic in_win, kc_wr, dd_wr, far_rd;
  assign in_win = bus_sel && (bus_addr[31:WIN_BITS] == BASE[31:WIN_BITS]);
  assign kc_wr  = in_win && bus_we && bus_addr[WIN_BITS-1:0] == 8'h00;
  assign dd_wr  = in_win && bus_we && bus_addr[WIN_BITS-1:0] == 8'h0C;
  assign far_rd = in_win && !bus_we && bus_addr[WIN_BITS-1:4] != '0;

  p_key_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> kbd_r);
  p_fwd_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !dsp_r);
  p_busy_write_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dd_wr && !dsp_r) |=> !disp_valid);
  p_ready_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kc_wr && !key_valid) |=> kbd_r == $past(kbd_r));
  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((kbd_r && kbd_ie) || (dsp_r && dsp_ie)) |=> irq);
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !((kbd_r && kbd_ie) || (dsp_r && dsp_ie)) |=> !irq);
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    far_rd |-> bus_rdata == 32'd0);
endmodule

bind kbd_disp_regs kbd_disp_regs_chk #(.BASE(BASE), .WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .key_valid(key_valid),
  .disp_valid(disp_valid), .irq(irq), .kbd_r(kbd_r), .kbd_ie(kbd_ie),
  .dsp_r(dsp_r), .dsp_ie(dsp_ie)
);

// File: tb/kbd_disp_regs_bench.sv
`timescale 1ns/1ps
module kbd_disp_regs_bench;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic        key_valid = 0, disp_ack = 0, disp_valid, irq;
  logic [7:0]  key_byte = 0, disp_byte;
  int checks = 0, errors = 0;

  localparam logic [31:0] KC = 32'hFFFF_0000, KD = 32'hFFFF_0004,
                          DC = 32'hFFFF_0008, DD = 32'hFFFF_000C;

  always #2.5 clk = ~clk;

  kbd_disp_regs u_kbd_disp_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_valid(key_valid), .key_byte(key_byte), .disp_valid(disp_valid),
    .disp_byte(disp_byte), .disp_ack(disp_ack), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_we = 0;
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk); key_valid = 1; key_byte = b;
    @(posedge clk); #1 key_valid = 0;
  endtask

  task automatic ack();
    @(negedge clk); disp_ack = 1;
    @(posedge clk); #1 disp_ack = 0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic dr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(KC, d); chk("R1 kbd ctrl", d, 0);
    rd(DC, d); chk("R1 disp ctrl", d, 1);
    chk("R1 irq", irq, 0);
    chk("R1 disp_valid", disp_valid, 0);

    // R8 unmapped offsets inside the window
    for (int o = 'h10; o < 'h100; o += 4) begin
      rd(32'hFFFF_0000 + o, d); chk("R8 unmapped", d, 0);
    end

    // R2 outside the window: reads zero, writes and reads without effect
    strobe(8'h5A);
    rd(32'hFFFE_0004, d); chk("R2 outside read", d, 0);
    rd(32'h0000_0004, d); chk("R2 outside read low", d, 0);
    wr(32'h7FFF_0000, 32'h2);
    wr(32'hFFFF_0100, 32'h2);
    rd(KC, d); chk("R2 no side effect", d, 1);

    // R3 every key byte
    for (int b = 0; b < 256; b++) begin
      strobe(b[7:0]);
      rd(KC, d); chk("R3 ready set", d, 1);
      rd(KD, d); chk("R3 data", d, b);
      rd(KC, d); chk("R3 ready cleared", d, 0);
    end

    // R3 strobe in the same cycle as a data read
    strobe(8'h11);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = KD;
    key_valid = 1; key_byte = 8'h22;
    #1 chk("R3 collide old byte", bus_rdata, 32'h11);
    @(posedge clk); #1 bus_sel = 0; key_valid = 0;
    rd(KC, d); chk("R3 collide ready kept", d, 1);
    rd(KD, d); chk("R3 collide new byte", d, 32'h22);

    // R4 display forward, R5 busy write ignored
    for (int b = 0; b < 256; b += 37) begin
      wr(DD, 32'hABCD_0000 | b);
      chk("R4 valid pulse", disp_valid, 1);
      chk("R4 byte", disp_byte, b);
      @(posedge clk); #1 chk("R4 single pulse", disp_valid, 0);
      rd(DC, d); chk("R4 busy", d, 0);
      wr(DD, 32'hFF ^ b);
      chk("R5 no pulse", disp_valid, 0);
      chk("R5 byte kept", disp_byte, b);
      rd(DD, d); chk("R4 readback", d, b);
      ack();
      rd(DC, d); chk("R4 ready after ack", d, 1);
    end

    // R6 control bits
    wr(KC, 32'hFFFF_FFFF); rd(KC, d); chk("R6 kbd ie, R ro", d, 2);
    wr(DC, 32'hFFFF_FFFE); rd(DC, d); chk("R6 disp ie, R ro", d, 3);
    wr(DC, 32'h0);         rd(DC, d); chk("R6 disp ie clear", d, 1);
    wr(KC, 32'h0);         rd(KC, d); chk("R6 kbd ie clear", d, 0);

    // R7 interrupt sweep
    dr = 1;
    for (int m = 0; m < 16; m++) begin
      wr(KC, {30'd0, m[0], 1'b0});
      wr(DC, {30'd0, m[1], 1'b0});
      if (m[2]) strobe(8'h33); else rd(KD, d);
      if (m[3] && !dr) begin ack(); dr = 1; end
      if (!m[3] && dr) begin wr(DD, 32'h44); dr = 0; end
      rd(KC, d); chk("R7 kbd ctrl", d, {30'd0, m[0], m[2]});
      rd(DC, d); chk("R7 disp ctrl", d, {30'd0, m[1], m[3]});
      chk("R7 irq", irq, (m[0] & m[2]) | (m[1] & m[3]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule